// File: doc/BRIEF.md
# Descriptor-Chain DMA Controller

This block is a bus-master DMA engine for a storage host port. Software builds a table of descriptors in memory. Each descriptor is two words at consecutive addresses: a data address, then a byte count. Software writes the table base to a register and sets the start bit in the control register. The engine then fetches descriptors one after another and moves whole 32-bit words. In one direction it reads memory and hands the words to the device side. In the other it accepts words from the device side and writes them to memory. It stops after the descriptor whose address word has bit 0 set.

Progress is reported in a sticky status register, and a level interrupt is raised for every status bit that is also set in the interrupt-enable register. Writing stop with start clear aborts a running transfer. The block reset bit in the control register returns the engine to idle.

Top module: `dchain_dma`

## Requirements
- R1: After reset the status register reads 0, `irq` is 0 and no memory request is made.
- R2: A control write with START (bit 0) = 1, STOP (bit 1) = 0, descriptor enable (bit 3) = 1 and block reset (bit 7) = 0, made while idle, sets ACT (status bit 0). The first memory read is then at the table base (register 3) and the second at base + 4.
- R3: Bit 0 of a descriptor address word marks the last descriptor. The data address used is the address word with bit 0 forced to 0, and it advances by 4 for each word.
- R4: With direction bit 2 = 0, the engine reads ceil(length/4) words from memory and presents them in order on `dev_out_data`. A word is taken when `dev_out_valid` and `dev_out_ready` are both high.
- R5: With direction bit 2 = 1, the engine takes each `dev_in_data` word when `dev_in_valid` and `dev_in_ready` are both high, and writes it to memory at the next data address.
- R6: After a descriptor that is not last, the next descriptor is fetched at the current descriptor address + 8. When the last descriptor finishes, ACT clears and NEND (status bit 1) sets.
- R7: Only the low 29 bits of the length word count. Higher bits do not change the number of words moved.
- R8: A control write with STOP = 1 and START = 0 while ACT is set clears ACT on the next cycle and sets the terminate bit (status bit 5). After that, no memory request is made.
- R9: A memory access answered with `mem_err` sets ERR (status bit 2), clears ACT and does not set NEND.
- R10: Status bits 1, 2, 4, 5 and 11 are sticky. Writing 1 to a bit of register 1 clears that bit, and writing 0 leaves it unchanged. ACT cannot be changed by a write.
- R11: `irq` is high exactly when some bit set in the status register is also set in the interrupt-enable register (register 2, same bit positions).
- R12: Setting block reset (control bit 7) clears ACT and every status bit. A start is ignored while block reset is set or descriptor enable is 0.
- R13: A one-cycle pulse on `dev_irq` sets status bit 4, and one on `link_irq` sets status bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 interrupt enable, 3 table base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt level |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_err | input | 1 | Memory error, valid with `mem_ack` |
| dev_out_valid | output | 1 | Word for the device side is valid |
| dev_out_ready | input | 1 | Device side takes the word |
| dev_out_data | output | 32 | Word for the device side |
| dev_in_valid | input | 1 | Word from the device side is valid |
| dev_in_ready | output | 1 | Engine takes the device word |
| dev_in_data | input | 32 | Word from the device side |
| dev_irq | input | 1 | Device interrupt event |
| link_irq | input | 1 | Link interrupt event |

## Verification
The assertions assume the memory side keeps its word. It acknowledges only a request that is present, and for one cycle at a time. `mem_rdata` and `mem_err` count only in the acknowledge cycle. The bench memory model acknowledges a new request one cycle after it appears and then drops the acknowledge for a cycle. It drives data and error only with that acknowledge. Stop and block-reset writes are issued while the engine sits stalled in a device handshake, so an abort never has to interrupt a memory handshake that is mid-way.

// File: rtl/dchain_dma.sv
module dchain_dma #(
  parameter int LEN_W = 29,
  parameter int WORD_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        dev_out_valid,
  input  logic        dev_out_ready,
  output logic [31:0] dev_out_data,
  input  logic        dev_in_valid,
  output logic        dev_in_ready,
  input  logic [31:0] dev_in_data,
  input  logic        dev_irq,
  input  logic        link_irq
);

  localparam logic [LEN_W-1:0] STEP = LEN_W'(WORD_BYTES);
  localparam logic [11:0] STAT_MASK = 12'h836;
  localparam logic [11:0] IEN_MASK  = 12'h837;

  typedef enum logic [2:0] {
    S_IDLE, S_FA, S_FL, S_MRD, S_DOUT, S_DIN, S_MWR
  } state_t;

  state_t state;
  logic c_dir, c_dese, c_rst, c_fmt, c_mode;
  logic [31:0] base, ptr, daddr, dbuf;
  logic [LEN_W-1:0] rem;
  logic last;
  logic [11:0] stat, ien;

  logic act, wr_ctl, wr_stat, wr_ien, wr_base;
  logic go, abort, rst_hit;
  logic acc_ok, acc_bad, word_done, desc_end;
  logic [LEN_W-1:0] len_in;
  logic [11:0] st_set, st_clr, st_full;

  assign act     = (state != S_IDLE);
  assign wr_ctl  = reg_we && (reg_addr == 2'd0);
  assign wr_stat = reg_we && (reg_addr == 2'd1);
  assign wr_ien  = reg_we && (reg_addr == 2'd2);
  assign wr_base = reg_we && (reg_addr == 2'd3);

  assign go      = wr_ctl && reg_wdata[0] && !reg_wdata[1] && reg_wdata[3]
                   && !reg_wdata[7] && !act;
  assign abort   = wr_ctl && reg_wdata[1] && !reg_wdata[0] && act;
  assign rst_hit = c_rst || (wr_ctl && reg_wdata[7]);

  assign mem_req = (state == S_FA) || (state == S_FL) ||
                   (state == S_MRD) || (state == S_MWR);
  assign mem_we  = (state == S_MWR);
  assign mem_wdata = dbuf;
  always_comb begin
    case (state)
      S_FA:    mem_addr = ptr;
      S_FL:    mem_addr = ptr + 32'd4;
      default: mem_addr = daddr;
    endcase
  end

  assign dev_out_valid = (state == S_DOUT);
  assign dev_out_data  = dbuf;
  assign dev_in_ready  = (state == S_DIN);

  assign acc_ok    = mem_req && mem_ack && !mem_err;
  assign acc_bad   = mem_req && mem_ack && mem_err;
  assign len_in    = mem_rdata[LEN_W-1:0];
  assign word_done = ((state == S_DOUT) && dev_out_ready) ||
                     ((state == S_MWR) && acc_ok);
  assign desc_end  = (word_done && (rem <= STEP)) ||
                     ((state == S_FL) && acc_ok && (len_in == '0));

  always_comb begin
    st_set     = '0;
    st_set[1]  = desc_end && last && !abort;
    st_set[2]  = acc_bad && !abort;
    st_set[4]  = dev_irq;
    st_set[5]  = abort;
    st_set[11] = link_irq;
    st_clr     = wr_stat ? reg_wdata[11:0] : '0;
    st_full    = stat;
    st_full[0] = act;
  end

  assign irq = |(st_full & ien);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[0]  = act;
        reg_rdata[2]  = c_dir;
        reg_rdata[3]  = c_dese;
        reg_rdata[7]  = c_rst;
        reg_rdata[11] = c_fmt;
        reg_rdata[16] = c_mode;
      end
      2'd1: reg_rdata[11:0] = st_full;
      2'd2: reg_rdata[11:0] = ien;
      default: reg_rdata = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      c_dir  <= 1'b0;
      c_dese <= 1'b0;
      c_rst  <= 1'b0;
      c_fmt  <= 1'b0;
      c_mode <= 1'b0;
      base   <= '0;
      ptr    <= '0;
      daddr  <= '0;
      dbuf   <= '0;
      rem    <= '0;
      last   <= 1'b0;
      stat   <= '0;
      ien    <= '0;
    end else begin
      if (wr_ctl) begin
        c_dir  <= reg_wdata[2];
        c_dese <= reg_wdata[3];
        c_rst  <= reg_wdata[7];
        c_fmt  <= reg_wdata[11];
        c_mode <= reg_wdata[16];
      end
      if (wr_ien)  ien  <= reg_wdata[11:0] & IEN_MASK;
      if (wr_base) base <= reg_wdata;

      if (rst_hit) stat <= '0;
      else         stat <= ((stat & ~st_clr) | st_set) & STAT_MASK;

      if (rst_hit || abort) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (go) begin
            ptr   <= base;
            state <= S_FA;
          end
          S_FA: if (acc_bad) state <= S_IDLE;
          else if (acc_ok) begin
            daddr <= {mem_rdata[31:1], 1'b0};
            last  <= mem_rdata[0];
            state <= S_FL;
          end
          S_FL: if (acc_bad) state <= S_IDLE;
          else if (acc_ok) begin
            rem <= len_in;
            if (len_in == '0) begin
              ptr   <= ptr + 32'd8;
              state <= last ? S_IDLE : S_FA;
            end else begin
              state <= c_dir ? S_DIN : S_MRD;
            end
          end
          S_MRD: if (acc_bad) state <= S_IDLE;
          else if (acc_ok) begin
            dbuf  <= mem_rdata;
            state <= S_DOUT;
          end
          S_DIN: if (dev_in_valid) begin
            dbuf  <= dev_in_data;
            state <= S_MWR;
          end
          S_DOUT, S_MWR: begin
            if (acc_bad) state <= S_IDLE;
            else if (word_done) begin
              daddr <= daddr + 32'(WORD_BYTES);
              if (rem <= STEP) begin
                rem   <= '0;
                ptr   <= ptr + 32'd8;
                state <= last ? S_IDLE : S_FA;
              end else begin
                rem   <= rem - STEP;
                state <= c_dir ? S_DIN : S_MRD;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort && !rst_hit) |=> (mem_req && $stable(mem_addr)));

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!act && stat[5]));

  a_r9_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> !act);

  a_r6_nend_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> !act);

  a_r12_blk_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[7]) |=> (!act && !mem_req && stat == 12'h000));

endmodule

// File: tb/dchain_dma_test.sv
module dchain_dma_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic mem_err = 1'b0;
  logic dev_out_valid;
  logic dev_out_ready = 1'b1;
  logic [31:0] dev_out_data;
  logic dev_in_valid = 1'b1;
  logic dev_in_ready;
  logic [31:0] dev_in_data;
  logic dev_irq = 1'b0;
  logic link_irq = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  logic [31:0] acc_log [0:63];
  int acc_n = 0;
  logic [31:0] out_log [0:63];
  int out_n = 0;
  int dev_cnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  always #10 clk = ~clk;

  assign dev_in_data = 32'h0000_A000 + 32'(dev_cnt);

  dchain_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_irq(dev_irq), .link_irq(link_irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      mem_err <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[9:2]];
        mem_err   <= (mem_addr == err_addr);
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (acc_n < 64) acc_log[acc_n] <= mem_addr;
        acc_n <= acc_n + 1;
      end
      if (dev_out_valid && dev_out_ready) begin
        if (out_n < 64) out_log[out_n] <= dev_out_data;
        out_n <= out_n + 1;
      end
      if (dev_in_valid && dev_in_ready) dev_cnt <= dev_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(2'd1, s);
      if (!s[0]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] s;
    @(negedge clk);
    rd(2'd1, s);
    check(s == 0, "R1 status after reset", s, 0);
    check(irq == 0 && mem_req == 0, "R1 irq/mem_req idle", {30'b0, irq, mem_req}, 0);
  endtask

  task automatic t_mem_to_dev();
    logic [31:0] s;
    int a0, o0;
    mem[16] = 32'h0000_0101;
    mem[17] = 32'hE000_000A;
    for (int i = 0; i < 4; i++) mem[64+i] = 32'h1111_0000 + 32'(i);
    wr(2'd3, 32'h40);
    a0 = acc_n; o0 = out_n;
    wr(2'd0, 32'h9);
    rd(2'd1, s);
    check(s[0] == 1, "R2 ACT set after start", s, 1);
    wait_idle();
    check(acc_log[a0] == 32'h40, "R2 first fetch at base", acc_log[a0], 32'h40);
    check(acc_log[a0+1] == 32'h44, "R2 length fetch at base+4", acc_log[a0+1], 32'h44);
    check(acc_log[a0+2] == 32'h100, "R3 data address bit0 masked", acc_log[a0+2], 32'h100);
    check(acc_log[a0+4] == 32'h108, "R3 address steps by 4", acc_log[a0+4], 32'h108);
    check(acc_n - a0 == 5, "R7 only low 29 length bits count", acc_n - a0, 5);
    check(out_n - o0 == 3, "R4 word count", out_n - o0, 3);
    for (int i = 0; i < 3; i++)
      check(out_log[o0+i] == 32'h1111_0000 + 32'(i), "R4 word order",
            out_log[o0+i], 32'h1111_0000 + 32'(i));
    rd(2'd1, s);
    check(s[1:0] == 2'b10, "R6 NEND set ACT clear", s, 32'h2);
  endtask

  task automatic t_irq_and_clear();
    logic [31:0] s;
    wr(2'd2, 32'h2);
    @(negedge clk);
    check(irq == 1, "R11 irq with NEND enabled", irq, 1);
    wr(2'd2, 32'h4);
    @(negedge clk);
    check(irq == 0, "R11 irq low when bit not enabled", irq, 0);
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0);
    rd(2'd1, s);
    check(s[1] == 1, "R10 write 0 keeps NEND", s, 32'h2);
    wr(2'd1, 32'h2);
    rd(2'd1, s);
    check(s == 0, "R10 write 1 clears NEND", s, 0);
  endtask

  task automatic t_chain_dev_to_mem();
    logic [31:0] s;
    int a0;
    mem[32] = 32'h200; mem[33] = 32'd8;
    mem[34] = 32'h281; mem[35] = 32'd4;
    dev_cnt = 0;
    wr(2'd3, 32'h80);
    a0 = acc_n;
    wr(2'd0, 32'hD);
    wait_idle();
    check(mem[128] == 32'hA000, "R5 first word written", mem[128], 32'hA000);
    check(mem[129] == 32'hA001, "R5 second word written", mem[129], 32'hA001);
    check(acc_log[a0+4] == 32'h88, "R6 next descriptor at +8", acc_log[a0+4], 32'h88);
    check(mem[160] == 32'hA002, "R6 second descriptor data", mem[160], 32'hA002);
    rd(2'd1, s);
    check(s[1:0] == 2'b10, "R6 chain ends with NEND", s, 32'h2);
    wr(2'd1, 32'hFFF);
  endtask

  task automatic t_stop();
    logic [31:0] s;
    int reqs;
    mem[48] = 32'h301; mem[49] = 32'd400;
    dev_out_ready = 1'b0;
    wr(2'd3, 32'hC0);
    wr(2'd0, 32'h9);
    repeat (10) @(negedge clk);
    wr(2'd1, 32'h1);
    rd(2'd1, s);
    check(s[0] == 1, "R10 ACT not writable", s, 1);
    wr(2'd0, 32'hA);
    rd(2'd1, s);
    check(s[0] == 0 && s[5] == 1, "R8 stop clears ACT sets terminate", s, 32'h20);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    check(reqs == 0, "R8 no request after stop", reqs, 0);
    dev_out_ready = 1'b1;
    wr(2'd1, 32'hFFF);
  endtask

  task automatic t_error();
    logic [31:0] s;
    err_addr = 32'h104;
    wr(2'd3, 32'h40);
    wr(2'd0, 32'h9);
    wait_idle();
    rd(2'd1, s);
    check(s[2] == 1 && s[1] == 0 && s[0] == 0, "R9 error ends without NEND", s, 32'h4);
    err_addr = 32'hFFFF_FFFF;
    wr(2'd1, 32'hFFF);
  endtask

  task automatic t_events();
    logic [31:0] s;
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    rd(2'd1, s);
    check(s[4] == 1, "R13 dev_irq sets bit 4", s, 32'h10);
    @(negedge clk); link_irq = 1'b1;
    @(negedge clk); link_irq = 1'b0;
    rd(2'd1, s);
    check(s[11] == 1, "R13 link_irq sets bit 11", s, 32'h810);
  endtask

  task automatic t_block_reset();
    logic [31:0] s;
    int reqs;
    dev_out_ready = 1'b0;
    wr(2'd3, 32'hC0);
    wr(2'd0, 32'h9);
    repeat (8) @(negedge clk);
    wr(2'd0, 32'h88);
    rd(2'd1, s);
    check(s == 0, "R12 block reset clears ACT and status", s, 0);
    dev_out_ready = 1'b1;
    wr(2'd0, 32'h89);
    reqs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    rd(2'd1, s);
    check(reqs == 0 && s[0] == 0, "R12 start ignored in block reset", reqs, 0);
    wr(2'd0, 32'h1);
    rd(2'd1, s);
    check(s[0] == 0, "R12 start ignored without descriptor enable", s, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mem_to_dev();
    t_irq_and_clear();
    t_chain_dev_to_mem();
    t_stop();
    t_error();
    t_events();
    t_block_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule